// File: doc/BRIEF.md
# Protected I2C Register Target

This block is an I2C target that gives a host access to a register space addressed by a 9-bit pointer. The host sets the pointer by sending one address byte after a write header. It then either streams data bytes in, or issues a repeated START with the read header and streams data bytes out. The pointer advances by one per data byte in both directions. The address byte maps one-to-one onto pointers 080h–0FEh, and the value FFh selects 100h, the start of the control area that ends at 10Fh.

Writes reach the attached register file through a one-cycle write strobe. Three conditions gate them. A write-enable latch, held in bit 7 of the control register at 105h, must be set. The active-low protect input must be high, although a byte written to 105h always updates the latch, even under protect. Finally, a commit strobe pulses only after a STOP that follows a complete, acknowledged data byte of a write in which at least one byte was accepted. The register file keeps written bytes in a volatile stage and makes them permanent only on that commit. When the pointer is on one of the first four control registers, reads select the nonvolatile copy. Reads outside 080h–10Fh return FFh.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset SDA is released, no strobe is active, and START (SDA falling while SCL is high) and STOP (SDA rising while SCL is high) are detected from two-flop synchronized SCL and SDA.
- R2: The target acknowledges a header whose upper seven bits equal 1010 followed by the DEV_SEL bits; any other header gets no acknowledge and SDA stays released.
- R3: An address byte of 80h–FEh sets the pointer to the same value, and FFh sets it to 100h.
- R4: Each data byte returned to the host comes from the current pointer, which then advances by one, so consecutive bytes come from consecutive locations.
- R5: Bytes read from a pointer below 080h or above 10Fh are FFh.
- R6: While the pointer is in 100h–103h the nonvolatile-select output is high, so those reads return the nonvolatile copy; at 104h it is low.
- R7: A data byte written while the latch is set and the protect input is high raises rf_we for one cycle, with the pointer on rf_addr and the byte on rf_wdata, and the pointer then advances.
- R8: With the latch clear, no data byte raises rf_we; a byte written to 105h still loads its bit 7 into the latch.
- R9: While the protect input is low, no byte raises rf_we, but a byte written to 105h still loads its bit 7 into the latch.
- R10: commit pulses for one cycle only on a STOP that follows an acknowledged data byte of a write that accepted at least one byte. A STOP inside a byte, or a write left by a repeated START, gives no pulse.
- R11: When the host answers a read byte with NACK, the target drives SDA no more until the next START.
- R12: The address byte and every write data byte are acknowledged, whether or not the write is accepted.
- R13: Data bytes written to a pointer outside 080h–10Fh never raise rf_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pulls SDA low when 1 (open drain) |
| wp_n | input | 1 | Write protect, active low |
| rf_addr | output | 9 | Register file address (current pointer) |
| rf_nv | output | 1 | Selects the nonvolatile copy for reads |
| rf_rdata | input | 8 | Register file read data, combinational on rf_addr |
| rf_wdata | output | 8 | Write data |
| rf_we | output | 1 | One-cycle write strobe |
| commit | output | 1 | One-cycle strobe making staged writes permanent |

## Verification
The bench reads across the whole control area starting from FFh. This catches a design that maps FFh to 0FFh, keeps selecting the nonvolatile copy past 103h, or returns stale memory instead of FFh after 10Fh. It first sets the latch while it is clear and later clears it under protect. This exposes a design that blocks latch updates along with other writes, which would leave every later write stuck. It ends one write with a STOP inside a byte and another with a repeated START into a read. A design that commits on any STOP would pulse commit in both cases, and the bench counts those pulses. After a NACK it keeps clocking and watches SDA, which catches a target that continues shifting out the next byte.

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [2:0] DEV_SEL   = 3'b000,
  parameter logic [8:0] WIN_LO    = 9'h080,
  parameter logic [8:0] WIN_HI    = 9'h10F,
  parameter logic [8:0] CTRL_BASE = 9'h100,
  parameter int         NV_CNT    = 4,
  parameter logic [8:0] WEL_ADDR  = 9'h105,
  parameter int         WEL_BIT   = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       wp_n,
  output logic [8:0] rf_addr,
  output logic       rf_nv,
  input  logic [7:0] rf_rdata,
  output logic [7:0] rf_wdata,
  output logic       rf_we,
  output logic       commit
);
  localparam logic [8:0] NV_END  = CTRL_BASE + 9'(NV_CNT);
  localparam logic [6:0] DEV_HDR = {4'b1010, DEV_SEL};

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_ACKD, S_ADDR, S_ACKA, S_WDAT, S_ACKW, S_RD, S_RACK, S_DONE
  } st_t;

  st_t        st;
  logic [2:0] scl_p, sda_p;
  logic [1:0] wp_p;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [8:0] ptr;
  logic       rw, wel, wr_seen, we_seen;

  logic scl_s, scl_q, sda_s, sda_q;
  assign scl_s = scl_p[1];
  assign scl_q = scl_p[2];
  assign sda_s = sda_p[1];
  assign sda_q = sda_p[2];

  logic rise, fall, start, stop;
  assign rise  = scl_s & ~scl_q;
  assign fall  = ~scl_s & scl_q;
  assign start = scl_s & scl_q & sda_q & ~sda_s;
  assign stop  = scl_s & scl_q & ~sda_q & sda_s;

  logic       in_win, wr_ok;
  logic [7:0] rd_byte;
  logic [8:0] map_ptr;
  assign in_win  = (ptr >= WIN_LO) && (ptr <= WIN_HI);
  assign wr_ok   = in_win && wel && wp_p[1];
  assign rd_byte = in_win ? rf_rdata : 8'hFF;
  assign map_ptr = (sh == 8'hFF) ? 9'h100 : {1'b0, sh};

  assign rf_addr  = ptr;
  assign rf_wdata = sh;
  assign rf_nv    = (ptr >= CTRL_BASE) && (ptr < NV_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
      wp_p  <= 2'b11;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
      wp_p  <= {wp_p[0], wp_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sh      <= '0;
      ptr     <= '0;
      rw      <= 1'b0;
      wel     <= 1'b0;
      wr_seen <= 1'b0;
      we_seen <= 1'b0;
      sda_oe  <= 1'b0;
      rf_we   <= 1'b0;
      commit  <= 1'b0;
    end else begin
      rf_we  <= 1'b0;
      commit <= 1'b0;
      if (start) begin
        st      <= S_DEV;
        cnt     <= '0;
        sda_oe  <= 1'b0;
        wr_seen <= 1'b0;
        we_seen <= 1'b0;
      end else if (stop) begin
        commit <= (st == S_WDAT) && (cnt == 4'd1) && wr_seen && we_seen;
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (rise) begin
        case (st)
          S_DEV, S_ADDR, S_WDAT:
            if (cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end
          S_RACK: if (sda_s) st <= S_DONE;
          default: ;
        endcase
      end else if (fall) begin
        case (st)
          S_DEV:
            if (cnt == 4'd8) begin
              if (sh[7:1] == DEV_HDR) begin
                st     <= S_ACKD;
                sda_oe <= 1'b1;
                rw     <= sh[0];
              end else begin
                st <= S_IDLE;
              end
            end
          S_ACKD, S_RACK:
            if (st == S_RACK || rw) begin
              sh     <= rd_byte;
              sda_oe <= ~rd_byte[7];
              ptr    <= ptr + 9'd1;
              cnt    <= 4'd1;
              st     <= S_RD;
            end else begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= S_ADDR;
            end
          S_ADDR:
            if (cnt == 4'd8) begin
              ptr    <= map_ptr;
              sda_oe <= 1'b1;
              st     <= S_ACKA;
            end
          S_ACKA: begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= S_WDAT;
          end
          S_WDAT:
            if (cnt == 4'd8) begin
              sda_oe  <= 1'b1;
              rf_we   <= wr_ok;
              we_seen <= we_seen | wr_ok;
              if (ptr == WEL_ADDR) wel <= sh[WEL_BIT];
              st      <= S_ACKW;
            end
          S_ACKW: begin
            sda_oe  <= 1'b0;
            cnt     <= '0;
            ptr     <= ptr + 9'd1;
            wr_seen <= 1'b1;
            st      <= S_WDAT;
          end
          S_RD:
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              st     <= S_RACK;
            end else begin
              sda_oe <= ~sh[6];
              sh     <= {sh[6:0], 1'b1};
              cnt    <= cnt + 4'd1;
            end
          default: ;
        endcase
      end
    end
  end
endmodule

module i2c_reg_target_chk #(
  parameter logic [8:0] LO = 9'h080,
  parameter logic [8:0] HI = 9'h10F
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       wp_n,
  input logic       rf_we,
  input logic       commit,
  input logic [8:0] rf_addr
);
  AST_PULL_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R12
  AST_WE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_addr >= LO && rf_addr <= HI)); // R13
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we); // R7
  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit); // R10
  AST_PROTECT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && $past(!wp_n) && $past(!wp_n, 2) && $past(!wp_n, 3)) |-> !rf_we); // R9
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.LO(WIN_LO), .HI(WIN_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .wp_n(wp_n),
  .rf_we(rf_we), .commit(commit), .rf_addr(rf_addr)
);

// File: tb/tb_i2c_reg_target.sv
`timescale 1ns/1ps
module tb_i2c_reg_target;
  localparam int Q = 6;
  localparam int H = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, wp_n = 1'b1;
  logic sda_oe, rf_nv, rf_we, commit;
  logic sda_i;
  logic [8:0] rf_addr;
  logic [7:0] rf_rdata, rf_wdata;

  always #4 clk = ~clk;

  assign sda_i = sda_m & ~sda_oe;

  i2c_reg_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_i), .sda_oe(sda_oe),
    .wp_n(wp_n), .rf_addr(rf_addr), .rf_nv(rf_nv), .rf_rdata(rf_rdata),
    .rf_wdata(rf_wdata), .rf_we(rf_we), .commit(commit)
  );

  logic [7:0] mem [0:511];
  int we_cnt = 0, cm_cnt = 0;
  int checks = 0, errors = 0;
  logic [7:0] wbuf [0:7];
  logic [7:0] rbuf [0:31];
  logic nack_seen;

  initial for (int i = 0; i < 512; i++) mem[i] = 8'(i) ^ 8'h3C;
  assign rf_rdata = rf_nv ? (8'hC0 | {6'b0, rf_addr[1:0]}) : mem[rf_addr];

  always @(posedge clk) begin
    if (rf_we) begin
      mem[rf_addr] <= rf_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (commit) cm_cnt <= cm_cnt + 1;
  end

  function automatic logic [7:0] init_val(input int a);
    return 8'(a) ^ 8'h3C;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; scl = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl = 1'b0; wt(Q);
  endtask

  task automatic bus_rstart;
    wt(Q); sda_m = 1'b1; wt(Q);
    scl = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop;
    wt(Q); sda_m = 1'b0; wt(Q);
    scl = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic send_bit(input logic b);
    wt(Q); sda_m = b; wt(Q);
    scl = 1'b1; wt(H);
    scl = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    wt(Q); sda_m = 1'b1; wt(Q);
    scl = 1'b1; wt(H / 2);
    b = sda_i; wt(H / 2);
    scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(ack);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(nack);
  endtask

  task automatic wr_tx(input logic [7:0] a, input int n, output logic acks);
    logic k;
    acks = 1'b0;
    bus_start;
    send_byte(8'hA0, k); acks |= k;
    send_byte(a, k); acks |= k;
    for (int i = 0; i < n; i++) begin send_byte(wbuf[i], k); acks |= k; end
    bus_stop;
    wt(8);
  endtask

  task automatic rd_tx(input logic [7:0] a, input int n, output logic acks);
    logic k;
    acks = 1'b0;
    bus_start;
    send_byte(8'hA0, k); acks |= k;
    send_byte(a, k); acks |= k;
    bus_rstart;
    send_byte(8'hA1, k); acks |= k;
    for (int i = 0; i < n; i++) recv_byte(i == n - 1, rbuf[i]);
    bus_stop;
    wt(8);
  endtask

  task automatic t_reset;
    chk("R1 sda released after reset", sda_oe, 0);
    chk("R1 no write strobe after reset", rf_we, 0);
    chk("R1 no commit after reset", commit, 0);
  endtask

  task automatic t_bad_header;
    logic k;
    bus_start;
    send_byte(8'hA2, k);
    chk("R2 foreign header not acked", k, 1);
    bus_stop;
    wt(8);
    chk("R2 sda released after foreign header", sda_oe, 0);
  endtask

  task automatic t_ctrl_sweep;
    logic a;
    logic [7:0] e;
    rd_tx(8'hFF, 17, a);
    chk("R2 R12 headers and address acked", a, 0);
    for (int k = 0; k < 17; k++) begin
      if (k < 4) e = 8'hC0 | 8'(k);
      else if (k < 16) e = init_val(256 + k);
      else e = 8'hFF;
      if (k < 4) chk("R6 R3 nonvolatile copy from FFh start", rbuf[k], e);
      else if (k < 16) chk("R4 control area sequential read", rbuf[k], e);
      else chk("R5 read past 10Fh gives FFh", rbuf[k], e);
    end
  endtask

  task automatic t_plain_reads;
    logic a;
    rd_tx(8'h8E, 2, a);
    chk("R3 read at 8Eh", rbuf[0], init_val(9'h08E));
    chk("R4 pointer advanced to 8Fh", rbuf[1], init_val(9'h08F));
    rd_tx(8'h10, 1, a);
    chk("R5 read below 80h gives FFh", rbuf[0], 8'hFF);
  endtask

  task automatic t_nack_release;
    logic k, b;
    logic [7:0] d;
    bus_start;
    send_byte(8'hA0, k);
    send_byte(8'h90, k);
    bus_rstart;
    send_byte(8'hA1, k);
    recv_byte(1'b1, d);
    nack_seen = 1'b0;
    for (int i = 0; i < 9; i++) begin
      recv_bit(b);
      if (!b) nack_seen = 1'b1;
    end
    chk("R11 no drive after host NACK", nack_seen, 0);
    bus_stop;
    wt(8);
  endtask

  task automatic t_wel_clear_blocks;
    logic a;
    int w0, c0;
    w0 = we_cnt; c0 = cm_cnt;
    wbuf[0] = 8'h55;
    wr_tx(8'h90, 1, a);
    chk("R12 blocked write still acked", a, 0);
    chk("R8 latch clear blocks strobe", we_cnt - w0, 0);
    chk("R10 no commit without accepted byte", cm_cnt - c0, 0);
    rd_tx(8'h90, 1, a);
    chk("R8 location unchanged", rbuf[0], init_val(9'h090));
  endtask

  task automatic set_wel(input logic v);
    logic a;
    for (int i = 0; i < 5; i++) wbuf[i] = 8'h00;
    wbuf[5] = {v, 7'h00};
    wr_tx(8'hFF, 6, a);
  endtask

  task automatic t_accepted_write;
    logic a;
    int w0, c0;
    w0 = we_cnt;
    set_wel(1'b1);
    chk("R8 latch write itself raises no strobe", we_cnt - w0, 0);
    w0 = we_cnt; c0 = cm_cnt;
    wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
    wr_tx(8'h90, 2, a);
    chk("R7 two strobes for two bytes", we_cnt - w0, 2);
    chk("R10 one commit after clean STOP", cm_cnt - c0, 1);
    rd_tx(8'h90, 2, a);
    chk("R7 first byte stored", rbuf[0], 8'h5A);
    chk("R7 second byte at next location", rbuf[1], 8'hC3);
  endtask

  task automatic t_protect;
    logic a;
    int w0, c0;
    wp_n = 1'b0; wt(8);
    w0 = we_cnt; c0 = cm_cnt;
    wbuf[0] = 8'h11;
    wr_tx(8'h94, 1, a);
    chk("R9 protect blocks strobe", we_cnt - w0, 0);
    chk("R9 protect gives no commit", cm_cnt - c0, 0);
    set_wel(1'b0);
    chk("R9 latch write under protect raises no strobe", we_cnt - w0, 0);
    wp_n = 1'b1; wt(8);
    wbuf[0] = 8'h22;
    wr_tx(8'h98, 1, a);
    chk("R9 latch cleared under protect blocks later write", we_cnt - w0, 0);
    rd_tx(8'h98, 1, a);
    chk("R9 location unchanged", rbuf[0], init_val(9'h098));
    set_wel(1'b1);
  endtask

  task automatic t_bad_framing;
    logic k;
    logic [7:0] d;
    int w0, c0;
    w0 = we_cnt; c0 = cm_cnt;
    bus_start;
    send_byte(8'hA0, k);
    send_byte(8'h9A, k);
    send_byte(8'h77, k);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_stop;
    wt(8);
    chk("R7 complete byte before broken one stored", we_cnt - w0, 1);
    chk("R10 STOP inside byte gives no commit", cm_cnt - c0, 0);
    w0 = we_cnt; c0 = cm_cnt;
    bus_start;
    send_byte(8'hA0, k);
    send_byte(8'h9C, k);
    send_byte(8'h66, k);
    bus_rstart;
    send_byte(8'hA1, k);
    recv_byte(1'b1, d);
    bus_stop;
    wt(8);
    chk("R10 write left by repeated START gives no commit", cm_cnt - c0, 0);
    chk("R4 read continues after written byte", d, init_val(9'h09D));
    chk("R7 byte before repeated START strobed", we_cnt - w0, 1);
  endtask

  task automatic t_out_of_window;
    logic a;
    int w0, c0;
    w0 = we_cnt; c0 = cm_cnt;
    wbuf[0] = 8'h99;
    wr_tx(8'h20, 1, a);
    chk("R13 write below 80h raises no strobe", we_cnt - w0, 0);
    chk("R13 write below 80h gives no commit", cm_cnt - c0, 0);
    chk("R12 out of window byte acked", a, 0);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    wt(5);
    t_reset;
    rst_n = 1'b1;
    wt(10);
    t_reset;
    t_bad_header;
    t_ctrl_sweep;
    t_plain_reads;
    t_nack_release;
    t_wel_clear_blocks;
    t_accepted_write;
    t_protect;
    t_bad_framing;
    t_out_of_window;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule